// File: doc/BRIEF.md
# Two-Wire Serial Master Byte Controller

This block is the master side of a two-wire (I2C-style) serial interface. A host sets a master-request bit, and the block then claims the bus on its own. It generates a start condition and sends a 7-bit call address with a write direction bit. After that it sends each data byte the host loads, sampling the acknowledge after every byte. The bus lines are open-drain, so the block never drives a high level. It asserts a drive-low enable per line, and it reads the resolved line levels back through separate sample inputs.

The transfer ends in one of three ways. A NAK or a software clear of the request bit lets the current byte finish, then produces a stop condition, and any byte that is loaded but not yet sent is dropped. A transmit failure means the block drove a one but read a zero, which is the usual symptom of lost arbitration. In that case both lines are released at once and no stop is produced. A bus monitor watches the lines for start and stop conditions from any master and keeps a bus-busy flag. The block waits for that flag to clear before it claims the bus. A clock-rate select picks one of eight SCL periods, each a power-of-two number of system clocks.

States of the controller:
- `ST_IDLE`: lines released.
- `ST_START_A`: bus-free half period.
- `ST_START_B`: SDA low with SCL high, which is the start.
- `ST_BIT_LO` and `ST_BIT_HI`: the two halves of a data or address bit.
- `ST_ACK_LO` and `ST_ACK_HI`: the two halves of the acknowledge bit.
- `ST_HOLD`: SCL held low while waiting for data or a clear.
- `ST_STOP_A` and `ST_STOP_B`: SDA low, then SCL released. Returning to idle releases SDA, which forms the stop.

Transitions:
- IDLE→START_A when the request bit is set and the bus is not busy.
- START_A→START_B, then START_B→BIT_LO, with the address loaded into the shifter.
- BIT_LO→BIT_HI on each half period.
- BIT_HI→BIT_LO after a bit that is not the last, or BIT_HI→ACK_LO after the last bit.
- BIT_HI→IDLE on a transmit failure.
- ACK_LO→ACK_HI.
- ACK_HI→STOP_A on a NAK or when the request bit is clear.
- ACK_HI→BIT_LO when a byte is pending, otherwise ACK_HI→HOLD.
- HOLD→BIT_LO when a byte arrives, or HOLD→STOP_A when the request bit clears.
- STOP_A→STOP_B→IDLE.
- Any state→IDLE when the enable input is low.

Every transition except the one out of IDLE and the one on disable waits for a half-period tick.

Top module: `i2cm_master`

## Requirements
- R1: After the request bit is set, the block produces a start condition and then the address byte MSB first. The byte is the 7-bit call address in bits 7..1 and a 0 (write) in bit 0.
- R2: Bytes loaded while the request bit is set go out in load order after the address. A load while the request bit is clear is ignored, and the pending flag stays 0.
- R3: With rate select s, SCL has a period of 8·2^s system clocks, with low and high halves of equal length.
- R4: The acknowledge is sampled at the end of the high half of the 9th SCL pulse. If SDA is high there, the NAK flag sets, the request bit clears and a stop follows.
- R5: When software clears the request bit, the byte in flight and its acknowledge complete, then a stop is produced. A loaded byte that was not yet sent is discarded, and the pending flag clears at once.
- R6: If SDA reads low at the end of a high half in which the block released it, the transmit-fail flag sets and the request bit clears. Both drive-low outputs drop in that same cycle, and no stop follows.
- R7: The bus-busy flag sets after SDA falls while SCL is high, and it clears after SDA rises while SCL is high, whichever master caused the change.
- R8: A request made while the bus is busy holds both lines released until the bus becomes free, and the transfer then runs normally.
- R9: One cycle after enable is low, the request bit, the bus-busy, transmit-fail, NAK and pending flags are all 0 and both lines are released. A request set while disabled is ignored.
- R10: After reset, both lines are released and every flag and the request bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Interface enable |
| req_set | input | 1 | Pulse: write 1 to the master-request bit |
| req_clr | input | 1 | Pulse: write 0 to the master-request bit |
| call_addr | input | DATA_W-1 | Call address, captured on request |
| rate_sel | input | RATE_W | Clock-rate select, captured on request |
| tx_load | input | 1 | Pulse: load tx_data as the next byte |
| tx_data | input | DATA_W | Data byte to send |
| sda_i | input | 1 | Sampled SDA level |
| scl_i | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Drive SDA low |
| scl_oe | output | 1 | Drive SCL low |
| req_active | output | 1 | Master-request bit |
| data_pending | output | 1 | A loaded byte awaits transmission |
| bus_busy | output | 1 | Bus-busy flag |
| tx_fail | output | 1 | Transmit-fail flag |
| nak_flag | output | 1 | NAK flag |

## Verification
The bench builds the block with its default parameters: an 8-bit frame, a 3-bit rate select and a base half period of 4 clocks. These defaults give an 8-clock SCL period at select 0, so dozens of random multi-byte transfers fit in a short run. The slowest divider setting (1024 clocks) is still reachable within a single byte. A bench-side slave decodes the lines bit by bit, measures the SCL period and can NAK any chosen byte. It can also hold SDA low to imitate a competing master, or fake a start from another master to keep the bus busy.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_START_B,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_HOLD,
        ST_STOP_A,
        ST_STOP_B
    } i2cm_state_e;

    typedef struct packed {
        logic sda_low;
        logic scl_low;
    } i2cm_drive_t;

endpackage

// File: rtl/i2cm_rate_div.sv
module i2cm_rate_div #(
    parameter int RATE_W    = 3,
    parameter int BASE_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] sel,
    output logic              tick
);
    localparam int CNT_W = $clog2(BASE_HALF) + (1 << RATE_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // half-period length: BASE_HALF shifted by the select
    assign limit = CNT_W'(BASE_HALF) << sel;
    assign tick  = run && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda_i,
    input  logic scl_i,
    output logic busy
);
    logic sda_q;
    logic scl_q;
    logic start_seen;
    logic stop_seen;

    assign start_seen = scl_q && scl_i && sda_q && !sda_i;
    assign stop_seen  = scl_q && scl_i && !sda_q && sda_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            sda_q <= sda_i;
            scl_q <= scl_i;
            if (!en) begin
                busy <= 1'b0;
            end else if (start_seen) begin
                busy <= 1'b1;
            end else if (stop_seen) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             msb,
    output logic             last
);
    localparam int IDX_W = $clog2(WIDTH);

    logic [WIDTH-1:0] sh_q;
    logic [IDX_W-1:0] idx_q;

    assign msb  = sh_q[WIDTH-1];
    assign last = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= IDX_W'(WIDTH - 1);
        end else if (shift) begin
            sh_q  <= {sh_q[WIDTH-2:0], 1'b0};
            idx_q <= idx_q - IDX_W'(1);
        end
    end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
    import i2cm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RATE_W    = 3,
    parameter int BASE_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              req_set,
    input  logic              req_clr,
    input  logic [DATA_W-2:0] call_addr,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sda_i,
    input  logic              scl_i,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              req_active,
    output logic              data_pending,
    output logic              bus_busy,
    output logic              tx_fail,
    output logic              nak_flag
);
    localparam int ADDR_W = DATA_W - 1;

    i2cm_state_e state_q, state_d;

    logic              req_q, nak_q, fail_q, pend_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RATE_W-1:0] rate_q;

    logic tick, busy;
    logic sh_bit, sh_last;
    logic ld_addr, ld_data, sh_step;
    logic arb_lost, got_nak;
    logic req_drop, req_take;
    i2cm_drive_t drv;

    i2cm_rate_div #(
        .RATE_W   (RATE_W),
        .BASE_HALF(BASE_HALF)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q != ST_IDLE),
        .sel  (rate_q),
        .tick (tick)
    );

    i2cm_bus_mon u_mon (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .sda_i(sda_i),
        .scl_i(scl_i),
        .busy (busy)
    );

    i2cm_shifter #(
        .WIDTH(DATA_W)
    ) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_addr || ld_data),
        .load_val(ld_addr ? {addr_q, 1'b0} : data_q),
        .shift   (sh_step),
        .msb     (sh_bit),
        .last    (sh_last)
    );

    // next state and transfer events
    always_comb begin
        state_d  = state_q;
        ld_addr  = 1'b0;
        ld_data  = 1'b0;
        sh_step  = 1'b0;
        arb_lost = 1'b0;
        got_nak  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_q && !busy) state_d = ST_START_A;
            end
            ST_START_A: begin
                if (tick) state_d = ST_START_B;
            end
            ST_START_B: begin
                if (tick) begin
                    state_d = ST_BIT_LO;
                    ld_addr = 1'b1;
                end
            end
            ST_BIT_LO: begin
                if (tick) state_d = ST_BIT_HI;
            end
            ST_BIT_HI: begin
                if (tick) begin
                    if (sh_bit && !sda_i) begin
                        arb_lost = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (sh_last) begin
                        state_d = ST_ACK_LO;
                    end else begin
                        sh_step = 1'b1;
                        state_d = ST_BIT_LO;
                    end
                end
            end
            ST_ACK_LO: begin
                if (tick) state_d = ST_ACK_HI;
            end
            ST_ACK_HI: begin
                if (tick) begin
                    if (sda_i) begin
                        got_nak = 1'b1;
                        state_d = ST_STOP_A;
                    end else if (!req_q) begin
                        state_d = ST_STOP_A;
                    end else if (pend_q) begin
                        ld_data = 1'b1;
                        state_d = ST_BIT_LO;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (!req_q) begin
                        state_d = ST_STOP_A;
                    end else if (pend_q) begin
                        ld_data = 1'b1;
                        state_d = ST_BIT_LO;
                    end
                end
            end
            ST_STOP_A: begin
                if (tick) state_d = ST_STOP_B;
            end
            ST_STOP_B: begin
                if (tick) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!en) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_drop = arb_lost || got_nak || req_clr;
    assign req_take = req_set && !req_q;

    // request bit, flags and data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            nak_q  <= 1'b0;
            fail_q <= 1'b0;
            pend_q <= 1'b0;
            data_q <= '0;
            addr_q <= '0;
            rate_q <= '0;
        end else if (!en) begin
            req_q  <= 1'b0;
            nak_q  <= 1'b0;
            fail_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (req_drop) begin
                req_q <= 1'b0;
            end else if (req_take) begin
                req_q  <= 1'b1;
                addr_q <= call_addr;
                rate_q <= rate_sel;
            end

            if (arb_lost) begin
                fail_q <= 1'b1;
            end else if (req_take && !req_drop) begin
                fail_q <= 1'b0;
            end

            if (got_nak) begin
                nak_q <= 1'b1;
            end else if (req_take && !req_drop) begin
                nak_q <= 1'b0;
            end

            if (req_drop) begin
                pend_q <= 1'b0;
            end else if (tx_load && req_q) begin
                pend_q <= 1'b1;
                data_q <= tx_data;
            end else if (ld_data) begin
                pend_q <= 1'b0;
            end
        end
    end

    // line drive per state
    always_comb begin
        drv = '0;
        unique case (state_q)
            ST_IDLE:    drv = '0;
            ST_START_A: drv = '0;
            ST_START_B: drv = '{sda_low: 1'b1, scl_low: 1'b0};
            ST_BIT_LO:  drv = '{sda_low: !sh_bit, scl_low: 1'b1};
            ST_BIT_HI:  drv = '{sda_low: !sh_bit, scl_low: 1'b0};
            ST_ACK_LO:  drv = '{sda_low: 1'b0, scl_low: 1'b1};
            ST_ACK_HI:  drv = '0;
            ST_HOLD:    drv = '{sda_low: 1'b0, scl_low: 1'b1};
            ST_STOP_A:  drv = '{sda_low: 1'b1, scl_low: 1'b1};
            ST_STOP_B:  drv = '{sda_low: 1'b1, scl_low: 1'b0};
            default:    drv = '0;
        endcase
    end

    assign sda_oe       = drv.sda_low;
    assign scl_oe       = drv.scl_low;
    assign req_active   = req_q;
    assign data_pending = pend_q;
    assign bus_busy     = busy;
    assign tx_fail      = fail_q;
    assign nak_flag     = nak_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sda_oe,
    input logic scl_oe,
    input logic req_active,
    input logic data_pending,
    input logic bus_busy,
    input logic tx_fail,
    input logic nak_flag
);
    // R2: a byte can only be waiting while the request bit is set
    a_r2_pending_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        data_pending |-> req_active);

    // R4: a NAK has cleared the request bit and the stop sequence holds SCL low
    a_r4_nak_clears_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nak_flag) |-> (!req_active && scl_oe));

    // R6: transmit failure releases both lines in the same cycle
    a_r6_fail_releases_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_fail) |-> (!sda_oe && !scl_oe && !req_active));

    // R7: own start (SDA pulled while SCL free) is seen by the bus monitor
    a_r7_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && !$past(scl_oe) && en) |=> (bus_busy || !en));

    // R7: own stop (SDA let go while SCL free) clears the busy flag
    a_r7_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe && !$past(scl_oe)) |=> !bus_busy);

    // R9: disabling returns every flag and both lines to rest
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!req_active && !bus_busy && !tx_fail && !nak_flag
                 && !data_pending && !sda_oe && !scl_oe));
endmodule

bind i2cm_master i2cm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .sda_oe      (sda_oe),
    .scl_oe      (scl_oe),
    .req_active  (req_active),
    .data_pending(data_pending),
    .bus_busy    (bus_busy),
    .tx_fail     (tx_fail),
    .nak_flag    (nak_flag)
);

// File: tb/tb_i2cm_master.sv
module tb_i2cm_master;
    localparam int SEED = 32'h5EED_0042;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       req_set = 1'b0, req_clr = 1'b0, tx_load = 1'b0;
    logic [6:0] call_addr = '0;
    logic [2:0] rate_sel = '0;
    logic [7:0] tx_data = '0;
    logic       sda_oe, scl_oe, req_active, data_pending, bus_busy, tx_fail, nak_flag;
    logic       slave_low = 1'b0, steal_low = 1'b0, ext_low = 1'b0;
    logic       steal_arm = 1'b0;
    logic       sda_i, scl_i;

    assign sda_i = !(sda_oe || slave_low || steal_low || ext_low);
    assign scl_i = !scl_oe;

    always #4 clk = ~clk;

    i2cm_master dut (
        .clk(clk), .rst_n(rst_n), .en(en), .req_set(req_set), .req_clr(req_clr),
        .call_addr(call_addr), .rate_sel(rate_sel), .tx_load(tx_load), .tx_data(tx_data),
        .sda_i(sda_i), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .req_active(req_active), .data_pending(data_pending), .bus_busy(bus_busy),
        .tx_fail(tx_fail), .nak_flag(nak_flag)
    );

    int checks = 0, errors = 0;
    int cyc = 0, starts = 0, stops = 0, nbytes = 0, bcnt = 0;
    int period = 0, last_rise = 0, nak_at = -1;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] sh = '0;
    logic [7:0] cap [0:7];
    logic [7:0] exp_d [0:7];

    // bench-side slave / line decoder
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        p_scl <= scl_i;
        p_sda <= sda_i;
        if (scl_i && p_scl && p_sda && !sda_i) begin
            starts    <= starts + 1;
            bcnt      <= 0;
            nbytes    <= 0;
            slave_low <= 1'b0;
        end else if (scl_i && p_scl && !p_sda && sda_i) begin
            stops <= stops + 1;
        end else if (scl_i && !p_scl) begin
            if (bcnt < 8) sh <= {sh[6:0], sda_i};
            if (bcnt == 7) begin
                cap[nbytes & 7] <= {sh[6:0], sda_i};
                nbytes <= nbytes + 1;
            end
            if (bcnt >= 1 && bcnt <= 7) period <= cyc - last_rise;
            last_rise <= cyc;
            bcnt      <= bcnt + 1;
        end else if (!scl_i && p_scl) begin
            if (bcnt == 8) begin
                slave_low <= ((nbytes - 1) != nak_at);
            end else if (bcnt == 9) begin
                slave_low <= 1'b0;
                bcnt      <= 0;
            end
            if (steal_arm && bcnt == 0 && nbytes == 0) steal_low <= 1'b1;
        end
        if (!steal_arm) steal_low <= 1'b0;
    end

    function automatic int exp_period(input int s);
        return 8 << s;
    endfunction

    function automatic int addr_byte(input logic [6:0] a);
        return int'({a, 1'b0});
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_set();
        req_set = 1'b1; @(negedge clk); req_set = 1'b0;
    endtask

    task automatic pulse_clr();
        req_clr = 1'b1; @(negedge clk); req_clr = 1'b0;
    endtask

    task automatic load(input logic [7:0] d);
        tx_data = d; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic wait_idle();
        while (req_active || bus_busy || scl_oe || sda_oe) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // address then n bytes from exp_d; clear after the last is taken
    task automatic do_xfer(input logic [6:0] a, input int n, input logic [2:0] s, input int nk);
        nak_at = nk; call_addr = a; rate_sel = s;
        pulse_set();
        for (int i = 0; i < n; i++) begin
            while (data_pending && req_active) @(negedge clk);
            load(exp_d[i]);
        end
        while (data_pending && req_active) @(negedge clk);
        pulse_clr();
        wait_idle();
    endtask

    initial begin
        int s0, n, s;
        logic [6:0] a;
        void'($urandom(SEED));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 lines", {30'd0, sda_oe, scl_oe}, 0);
        chk("R10 flags", {27'd0, req_active, data_pending, bus_busy, tx_fail, nak_flag}, 0);
        rst_n = 1'b1; en = 1'b1;
        repeat (2) @(negedge clk);

        // R2: load with request clear is ignored
        load(8'hC3);
        chk("R2 load ignored", int'(data_pending), 0);

        // R1 R2 R3 directed write, select 0
        exp_d[0] = 8'h3C; exp_d[1] = 8'hA5;
        s0 = stops;
        do_xfer(7'h5A, 2, 3'd0, -1);
        chk("R1 address byte", int'(cap[0]), addr_byte(7'h5A));
        chk("R2 byte0", int'(cap[1]), 8'h3C);
        chk("R2 byte1", int'(cap[2]), 8'hA5);
        chk("R5 count", nbytes, 3);
        chk("R5 stop", stops - s0, 1);
        chk("R3 period s0", period, exp_period(0));
        chk("R4 no nak", int'(nak_flag), 0);

        // random transfers
        for (int t = 0; t < 8; t++) begin
            a = 7'($urandom());
            n = 1 + int'($urandom_range(2));
            s = int'($urandom_range(2));
            for (int i = 0; i < n; i++) exp_d[i] = 8'($urandom());
            s0 = stops;
            do_xfer(a, n, 3'(s), -1);
            chk("R1 rnd address", int'(cap[0]), addr_byte(a));
            for (int i = 0; i < n; i++) chk("R2 rnd data", int'(cap[i + 1]), int'(exp_d[i]));
            chk("R2 rnd count", nbytes, n + 1);
            chk("R3 rnd period", period, exp_period(s));
            chk("R5 rnd stop", stops - s0, 1);
        end

        // R3 slower selects
        exp_d[0] = 8'h81;
        do_xfer(7'h11, 1, 3'd3, -1);
        chk("R3 period s3", period, exp_period(3));
        do_xfer(7'h22, 1, 3'd7, -1);
        chk("R3 period s7", period, exp_period(7));

        // R4 NAK on the address with a byte pending: no data goes out
        exp_d[0] = 8'h77; exp_d[1] = 8'h66;
        s0 = stops;
        do_xfer(7'h30, 2, 3'd0, 0);
        chk("R4 nak flag", int'(nak_flag), 1);
        chk("R4 request cleared", int'(req_active), 0);
        chk("R4 only address", nbytes, 1);
        chk("R4 stop", stops - s0, 1);
        chk("R5 pending dropped", int'(data_pending), 0);

        // R4 NAK on the first data byte
        exp_d[0] = 8'h12; exp_d[1] = 8'h34; exp_d[2] = 8'h56;
        do_xfer(7'h31, 3, 3'd1, 1);
        chk("R4 nak data", int'(nak_flag), 1);
        chk("R4 nak count", nbytes, 2);

        // R5 software clear while a byte is in flight and another waits
        call_addr = 7'h44; rate_sel = 3'd1; nak_at = -1;
        s0 = stops;
        pulse_set();
        chk("R4 nak cleared by new request", int'(nak_flag), 0);
        load(8'hE1);
        while (data_pending) @(negedge clk);
        load(8'hE2);
        pulse_clr();
        chk("R5 pending cleared", int'(data_pending), 0);
        chk("R5 bus still held", int'(bus_busy), 1);
        wait_idle();
        chk("R5 finished byte", int'(cap[1]), 8'hE1);
        chk("R5 dropped byte", nbytes, 2);
        chk("R5 deferred stop", stops - s0, 1);

        // R6 transmit failure on the first address bit
        call_addr = 7'h55; rate_sel = 3'd0; steal_arm = 1'b1;
        s0 = stops;
        pulse_set();
        while (!tx_fail) @(negedge clk);
        chk("R6 lines released", {30'd0, sda_oe, scl_oe}, 0);
        chk("R6 request cleared", int'(req_active), 0);
        repeat (10) @(negedge clk);
        chk("R6 no stop", stops - s0, 0);
        chk("R7 busy kept", int'(bus_busy), 1);
        steal_arm = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 stop frees bus", int'(bus_busy), 0);

        // R7 R8 another master's start holds the request back
        ext_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 foreign start", int'(bus_busy), 1);
        call_addr = 7'h0F; rate_sel = 3'd0;
        pulse_set();
        repeat (40) @(negedge clk);
        chk("R8 waits", {30'd0, sda_oe, scl_oe}, 0);
        ext_low = 1'b0;
        load(8'h9D);
        while (data_pending) @(negedge clk);
        pulse_clr();
        wait_idle();
        chk("R8 address after wait", int'(cap[0]), addr_byte(7'h0F));
        chk("R8 data after wait", int'(cap[1]), 8'h9D);

        // R9 disable mid transfer
        call_addr = 7'h66; rate_sel = 3'd1;
        pulse_set();
        load(8'h5F);
        while (nbytes != 1) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 cleared", {26'd0, req_active, data_pending, bus_busy, tx_fail, nak_flag, sda_oe}, 0);
        chk("R9 scl released", int'(scl_oe), 0);
        pulse_set();
        chk("R9 request ignored", int'(req_active), 0);
        en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 stays idle", {29'd0, req_active, sda_oe, scl_oe}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule